// File: doc/BRIEF.md
# Quad-Channel Serial DAC Write Controller

This block is the host-side driver for a serial digital-to-analog converter with four output channels. The host hands over one write request at a time: a 2-bit channel number and a 12-bit code. The block turns the request into a 16-bit serial frame. It drives the device select, the serial clock and the serial data line, then pulses an active-low update strobe. The converter moves the shifted code into the addressed channel's output register on the falling edge of that strobe.

The block can also put the converter into a known state. On request it sets a reset-select level first and then holds an active-low device reset low for a minimum time. Every setup, hold and pulse width on the device side is a parameter in nanoseconds. The block rounds each one up to whole cycles of the system clock from a clock-period parameter. With the default 8 ns period the counts are: data setup 4, data hold 3, clock high 4, clock low 7, select lead 7, select lag 2, strobe lead 5, strobe lag 2, strobe low 6, reset-select setup 4, reset low 9.

Top module: `qdac_writer`

## Requirements
- R1: Each frame has exactly 16 rising edges of `ser_clk` while `ser_sel_n` is low. The bits on `ser_dat` at those edges are, in order: channel bit 1, channel bit 0, two zero bits, then code bits 11 down to 0.
- R2: `ser_dat` is stable for at least the data-setup count of cycles before every rising edge of `ser_clk`. It does not change until at least the data-hold count of cycles after that edge.
- R3: `ser_clk` stays high for at least the clock-high count and low for at least the clock-low count. It is low whenever `ser_sel_n` is high, and `ser_sel_n` is high when idle.
- R4: `ser_sel_n` falls at least the select-lead count of cycles before the first rising edge of a frame. It rises no sooner than the select-lag count of cycles after the last rising edge.
- R5: `upd_n` is high for at least the strobe-lead count before every rising edge of `ser_clk`. Each frame is followed by exactly one low pulse. That pulse starts no sooner than the strobe-lag count after the last rising edge, occurs only while `ser_sel_n` is high, and lasts at least the strobe-low count.
- R6: `wr_ready` is high only when the block is idle and no reset is requested. A request is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `busy` is high from the next cycle until the cycle in which `upd_n` returns high, and it drops in that same cycle.
- R7: A reset request taken while idle copies `rst_sel` onto `dev_rst_lvl` at once. `dev_rst_n` falls no sooner than the reset-select setup count later and stays low for at least the reset-low count. `dev_rst_lvl` holds steady while `dev_rst_n` is low. `ser_sel_n` and `upd_n` stay high for the whole sequence.
- R8: If `rst_req` and `wr_valid` are both high while idle, the reset sequence runs first and `wr_ready` stays low. A write that is still pending is accepted after the reset sequence ends.
- R9: `ser_dat` is zero whenever `ser_sel_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low block reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request can be taken this cycle |
| wr_addr | input | 2 | Target channel number |
| wr_code | input | 12 | Code for the target channel |
| rst_req | input | 1 | Request a device reset sequence |
| rst_sel | input | 1 | Reset-select level to apply |
| busy | output | 1 | A write or reset sequence is in progress |
| ser_sel_n | output | 1 | Device select, active low |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_dat | output | 1 | Serial data, sampled by the device on rising `ser_clk` |
| upd_n | output | 1 | Output-update strobe, active low |
| dev_rst_n | output | 1 | Device reset, active low |
| dev_rst_lvl | output | 1 | Reset-select level held for the device |

## Verification
The hardest case to reach from the ports is a reset request and a write request arriving in the same idle cycle. The block must hold the write off, run the full reset sequence with the serial bus quiet, and then send the still-pending frame intact. The bench raises both requests on one falling clock edge, leaves `wr_valid` high through the reset, and checks the following frame bit by bit. The main sweep sends every channel with sixteen code patterns (all zeros, all ones, both alternating patterns and a walking one). A monitor at every falling clock edge checks every setup, hold and width rule on each edge.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int ADDR_W  = 2;
  localparam int PAD_W   = 2;
  localparam int CODE_W  = 12;
  localparam int FRAME_W = ADDR_W + PAD_W + CODE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_STROBE, ST_RSETUP, ST_RPULSE
  } qdac_state_e;

  // whole system clocks covering a time in ns, never below one
  function automatic int ns_to_cyc(int ns, int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // channel first, zero padding, code msb first
  function automatic logic [FRAME_W-1:0] build_frame(logic [ADDR_W-1:0] a,
                                                     logic [CODE_W-1:0] c);
    return {a, {PAD_W{1'b0}}, c};
  endfunction
endpackage

// File: rtl/qdac_timer.sv
module qdac_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic          shift,
  input  logic          clear,
  output logic          dat,
  output logic          last
);
  localparam int CW = $clog2(FW);

  logic [FW-1:0] sr;
  logic [CW-1:0] sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      sent <= '0;
    end else if (clear) begin
      sr   <= '0;
      sent <= '0;
    end else if (load) begin
      sr   <= frame;
      sent <= '0;
    end else if (shift) begin
      sr   <= {sr[FW-2:0], 1'b0};
      sent <= sent + 1'b1;
    end
  end

  assign dat  = sr[FW-1];
  assign last = (sent == CW'(FW - 1));
endmodule

// File: rtl/qdac_writer.sv
module qdac_writer
  import qdac_pkg::*;
#(
  parameter int CLK_PS     = 8000,
  parameter int T_DS_NS    = 25,
  parameter int T_DH_NS    = 20,
  parameter int T_CH_NS    = 30,
  parameter int T_CL_NS    = 50,
  parameter int T_CSS_NS   = 55,
  parameter int T_CSH_NS   = 15,
  parameter int T_LD1_NS   = 40,
  parameter int T_LD2_NS   = 15,
  parameter int T_LDW_NS   = 45,
  parameter int T_RSS_NS   = 25,
  parameter int T_RSTW_NS  = 70
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              rst_req,
  input  logic              rst_sel,
  output logic              busy,
  output logic              ser_sel_n,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              upd_n,
  output logic              dev_rst_n,
  output logic              dev_rst_lvl
);
  localparam int DS_C   = ns_to_cyc(T_DS_NS, CLK_PS);
  localparam int DH_C   = ns_to_cyc(T_DH_NS, CLK_PS);
  localparam int CH_C   = ns_to_cyc(T_CH_NS, CLK_PS);
  localparam int CL_C   = ns_to_cyc(T_CL_NS, CLK_PS);
  localparam int CSS_C  = ns_to_cyc(T_CSS_NS, CLK_PS);
  localparam int CSH_C  = ns_to_cyc(T_CSH_NS, CLK_PS);
  localparam int LD1_C  = ns_to_cyc(T_LD1_NS, CLK_PS);
  localparam int LD2_C  = ns_to_cyc(T_LD2_NS, CLK_PS);
  localparam int LDW_C  = ns_to_cyc(T_LDW_NS, CLK_PS);
  localparam int RSS_C  = ns_to_cyc(T_RSS_NS, CLK_PS);
  localparam int RSTW_C = ns_to_cyc(T_RSTW_NS, CLK_PS);

  // phase lengths: data changes on falling edges, so hold rides on the high phase
  localparam int HIGH_C = max2(CH_C, DH_C);
  localparam int LOW_C  = max2(CL_C, DS_C);
  localparam int LEAD_C = max2(max2(CSS_C, LOW_C), LD1_C);
  localparam int POST_C = max2(max2(HIGH_C, CSH_C), LD2_C);
  localparam int MAX_C  = max2(max2(max2(LEAD_C, POST_C), max2(LOW_C, LDW_C)),
                               max2(HIGH_C, max2(RSS_C, RSTW_C)));
  localparam int TW     = $clog2(MAX_C + 1);

  localparam logic [TW-1:0] LEAD_LD = TW'(LEAD_C - 1);
  localparam logic [TW-1:0] HIGH_LD = TW'(HIGH_C - 1);
  localparam logic [TW-1:0] LOW_LD  = TW'(LOW_C - 1);
  localparam logic [TW-1:0] POST_LD = TW'(POST_C - 1);
  localparam logic [TW-1:0] LDW_LD  = TW'(LDW_C - 1);
  localparam logic [TW-1:0] RSS_LD  = TW'(RSS_C - 1);
  localparam logic [TW-1:0] RSTW_LD = TW'(RSTW_C - 1);

  qdac_state_e state;
  logic        tmr_done, tmr_load, last_bit;
  logic [TW-1:0] tmr_val;

  // named events, also watched by the checker
  logic ev_rst_take, ev_accept, ev_rise, ev_fall_mid, ev_frame_end;
  logic ev_strobe_end, ev_rsetup_end, ev_rpulse_end;

  assign wr_ready      = (state == ST_IDLE) && !rst_req;
  assign ev_rst_take   = (state == ST_IDLE) && rst_req;
  assign ev_accept     = wr_valid && wr_ready;
  assign ev_rise       = tmr_done && ((state == ST_LEAD) || (state == ST_LOW));
  assign ev_fall_mid   = tmr_done && (state == ST_HIGH) && !last_bit;
  assign ev_frame_end  = tmr_done && (state == ST_HIGH) && last_bit;
  assign ev_strobe_end = tmr_done && (state == ST_STROBE);
  assign ev_rsetup_end = tmr_done && (state == ST_RSETUP);
  assign ev_rpulse_end = tmr_done && (state == ST_RPULSE);
  assign busy          = (state != ST_IDLE);

  assign tmr_load = ev_accept | ev_rst_take | ev_rise | ev_fall_mid |
                    ev_frame_end | ev_rsetup_end;

  always_comb begin
    tmr_val = '0;
    if (ev_accept)          tmr_val = LEAD_LD;
    else if (ev_rst_take)   tmr_val = RSS_LD;
    else if (ev_rise)       tmr_val = last_bit ? POST_LD : HIGH_LD;
    else if (ev_fall_mid)   tmr_val = LOW_LD;
    else if (ev_frame_end)  tmr_val = LDW_LD;
    else if (ev_rsetup_end) tmr_val = RSTW_LD;
  end

  qdac_timer #(.W(TW)) u_timer (
    .clk   (sys_clk),
    .rst_n (sys_rst_n),
    .load  (tmr_load),
    .val   (tmr_val),
    .done  (tmr_done)
  );

  qdac_shifter #(.FW(FRAME_W)) u_shift (
    .clk   (sys_clk),
    .rst_n (sys_rst_n),
    .load  (ev_accept),
    .frame (build_frame(wr_addr, wr_code)),
    .shift (ev_fall_mid),
    .clear (ev_frame_end),
    .dat   (ser_dat),
    .last  (last_bit)
  );

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      state       <= ST_IDLE;
      ser_sel_n   <= 1'b1;
      ser_clk     <= 1'b0;
      upd_n       <= 1'b1;
      dev_rst_n   <= 1'b1;
      dev_rst_lvl <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ev_rst_take) begin
            dev_rst_lvl <= rst_sel;
            state       <= ST_RSETUP;
          end else if (ev_accept) begin
            ser_sel_n <= 1'b0;
            state     <= ST_LEAD;
          end
        end
        ST_LEAD, ST_LOW: begin
          if (ev_rise) begin
            ser_clk <= 1'b1;
            state   <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (ev_frame_end) begin
            ser_clk   <= 1'b0;
            ser_sel_n <= 1'b1;
            upd_n     <= 1'b0;
            state     <= ST_STROBE;
          end else if (ev_fall_mid) begin
            ser_clk <= 1'b0;
            state   <= ST_LOW;
          end
        end
        ST_STROBE: begin
          if (ev_strobe_end) begin
            upd_n <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_RSETUP: begin
          if (ev_rsetup_end) begin
            dev_rst_n <= 1'b0;
            state     <= ST_RPULSE;
          end
        end
        ST_RPULSE: begin
          if (ev_rpulse_end) begin
            dev_rst_n <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qdac_writer_chk.sv
module qdac_writer_chk
  import qdac_pkg::*;
#(
  parameter int CLK_PS    = 8000,
  parameter int T_CH_NS   = 30,
  parameter int T_CL_NS   = 50,
  parameter int T_RSTW_NS = 70
) (
  input logic sys_clk,
  input logic sys_rst_n,
  input logic wr_ready,
  input logic rst_req,
  input logic busy,
  input logic ser_sel_n,
  input logic ser_clk,
  input logic ser_dat,
  input logic upd_n,
  input logic dev_rst_n,
  input logic dev_rst_lvl
);
  localparam int HI_MIN = ns_to_cyc(T_CH_NS, CLK_PS);
  localparam int LO_MIN = ns_to_cyc(T_CL_NS, CLK_PS);
  localparam int RW_MIN = ns_to_cyc(T_RSTW_NS, CLK_PS);

  logic [7:0] hi_run, lo_run, rl_run;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      hi_run <= '0;
      lo_run <= 8'hff;
      rl_run <= '0;
    end else begin
      hi_run <= ser_clk ? ((hi_run == 8'hff) ? hi_run : hi_run + 1'b1) : '0;
      lo_run <= !ser_clk ? ((lo_run == 8'hff) ? lo_run : lo_run + 1'b1) : '0;
      rl_run <= !dev_rst_n ? ((rl_run == 8'hff) ? rl_run : rl_run + 1'b1) : '0;
    end
  end

  a_r2_data_steady_at_rise: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(ser_clk) |-> $stable(ser_dat));
  a_r3_clock_low_when_deselected: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ser_sel_n |-> !ser_clk);
  a_r3_high_width: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $fell(ser_clk) |-> (int'(hi_run) >= HI_MIN));
  a_r3_low_width: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(ser_clk) |-> (int'(lo_run) >= LO_MIN));
  a_r5_update_while_deselected: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !upd_n |-> ser_sel_n);
  a_r6_ready_excludes_busy: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    wr_ready |-> !busy);
  a_r7_level_steady_in_pulse: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !dev_rst_n |-> $stable(dev_rst_lvl));
  a_r7_bus_quiet_in_reset: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !dev_rst_n |-> (ser_sel_n && upd_n));
  a_r7_reset_width: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(dev_rst_n) |-> (int'(rl_run) >= RW_MIN));
  a_r8_reset_blocks_write: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    rst_req |-> !wr_ready);
  a_r9_data_zero_when_deselected: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ser_sel_n |-> !ser_dat);
endmodule

bind qdac_writer qdac_writer_chk u_chk (
  .sys_clk     (sys_clk),
  .sys_rst_n   (sys_rst_n),
  .wr_ready    (wr_ready),
  .rst_req     (rst_req),
  .busy        (busy),
  .ser_sel_n   (ser_sel_n),
  .ser_clk     (ser_clk),
  .ser_dat     (ser_dat),
  .upd_n       (upd_n),
  .dev_rst_n   (dev_rst_n),
  .dev_rst_lvl (dev_rst_lvl)
);

// File: tb/qdac_writer_test.sv
module qdac_writer_test;
  logic        sys_clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_addr = '0;
  logic [11:0] wr_code = '0;
  logic        rst_req = 1'b0;
  logic        rst_sel = 1'b0;
  logic        busy, ser_sel_n, ser_clk, ser_dat, upd_n, dev_rst_n, dev_rst_lvl;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done_flag = 1'b0;

  always #4 sys_clk = ~sys_clk;

  qdac_writer uut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_code(wr_code), .rst_req(rst_req), .rst_sel(rst_sel),
    .busy(busy), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .upd_n(upd_n), .dev_rst_n(dev_rst_n), .dev_rst_lvl(dev_rst_lvl)
  );

  function automatic int need(int ns);
    return (ns * 1000 + 7999) / 8000;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // watchdog
  always @(posedge sys_clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  // bus monitor, sampling away from the active edge
  bit   mon_on = 1'b0;
  logic p_clk, p_sel, p_dat, p_upd, p_rst, p_lvl;
  int   dat_age, upd_age, lvl_age, since_rise, since_sel, clk_run, upd_run, rst_run;
  int   nbits, upd_pulses;
  logic [15:0] cap;
  logic [15:0] exp_frame;
  logic        exp_lvl;
  bit          first_rise;

  always @(negedge sys_clk) begin
    if (!mon_on) begin
      p_clk = ser_clk; p_sel = ser_sel_n; p_dat = ser_dat; p_upd = upd_n;
      p_rst = dev_rst_n; p_lvl = dev_rst_lvl;
      dat_age = 1000; upd_age = 1000; lvl_age = 1000; since_rise = 1000;
      since_sel = 1000; clk_run = 1000; upd_run = 1000; rst_run = 1000;
      nbits = 0; upd_pulses = 0; cap = '0; first_rise = 1'b0;
    end else begin
      dat_age = (ser_dat == p_dat) ? dat_age + 1 : 0;
      upd_age = (upd_n == p_upd) ? upd_age + 1 : 0;
      lvl_age = (dev_rst_lvl == p_lvl) ? lvl_age + 1 : 0;
      since_rise++;
      since_sel++;
      // R2 hold: data moves only after the hold count
      if (ser_dat != p_dat)
        chk(since_rise >= need(20), "R2 data hold", since_rise, need(20));
      // R9 data zero while deselected
      if (ser_sel_n)
        chk(ser_dat == 1'b0, "R9 data zero when deselected", ser_dat, 0);
      if (ser_clk != p_clk) begin
        if (p_clk) chk(clk_run + 1 >= need(30), "R3 clock high width", clk_run + 1, need(30));
        else       chk(clk_run + 1 >= need(50), "R3 clock low width", clk_run + 1, need(50));
        clk_run = 0;
      end else clk_run++;
      if (ser_clk && !p_clk) begin
        chk(dat_age >= need(25), "R2 data setup", dat_age, need(25));
        chk(upd_age >= need(40) && upd_n, "R5 strobe lead", upd_age, need(40));
        chk(!ser_sel_n, "R3 clock only while selected", ser_sel_n, 0);
        if (first_rise) begin
          chk(since_sel >= need(55), "R4 select lead", since_sel, need(55));
          first_rise = 1'b0;
        end
        cap = {cap[14:0], ser_dat};
        nbits++;
        since_rise = 0;
      end
      if (!ser_sel_n && p_sel) begin
        since_sel = 0; nbits = 0; upd_pulses = 0; first_rise = 1'b1;
      end
      if (ser_sel_n && !p_sel) begin
        chk(nbits == 16, "R1 edge count", nbits, 16);
        chk(cap == exp_frame, "R1 frame content", cap, exp_frame);
        chk(since_rise >= need(15), "R4 select lag", since_rise, need(15));
      end
      if (upd_n != p_upd) begin
        if (!upd_n) begin
          chk(since_rise >= need(15), "R5 strobe lag", since_rise, need(15));
          chk(ser_sel_n, "R5 strobe while deselected", ser_sel_n, 1);
          upd_pulses++;
        end else
          chk(upd_run + 1 >= need(45), "R5 strobe low width", upd_run + 1, need(45));
        upd_run = 0;
      end else upd_run++;
      if (dev_rst_n != p_rst) begin
        if (!dev_rst_n) begin
          chk(dev_rst_lvl == exp_lvl, "R7 reset level", dev_rst_lvl, exp_lvl);
          chk(lvl_age >= need(25), "R7 level setup", lvl_age, need(25));
        end else
          chk(rst_run + 1 >= need(70), "R7 reset low width", rst_run + 1, need(70));
        rst_run = 0;
      end else rst_run++;
      if (!dev_rst_n)
        chk(ser_sel_n && upd_n, "R7 bus quiet during reset", {ser_sel_n, upd_n}, 3);
      p_clk = ser_clk; p_sel = ser_sel_n; p_dat = ser_dat; p_upd = upd_n;
      p_rst = dev_rst_n; p_lvl = dev_rst_lvl;
    end
  end

  task automatic wait_idle();
    bit ready_seen = 1'b0;
    while (busy) begin
      if (wr_ready) ready_seen = 1'b1;
      @(negedge sys_clk);
    end
    chk(!ready_seen, "R6 no ready while busy", ready_seen, 0);
    chk(upd_n, "R6 busy drops with strobe high", upd_n, 1);
  endtask

  task automatic send(logic [1:0] a, logic [11:0] c);
    exp_frame = 16'(a * 16384 + c);
    wr_addr = a; wr_code = c; wr_valid = 1'b1;
    while (!wr_ready) @(negedge sys_clk);
    @(negedge sys_clk);
    wr_valid = 1'b0;
    chk(busy && !ser_sel_n, "R6 busy after accept", {busy, ser_sel_n}, 2);
    wait_idle();
    chk(upd_pulses == 1, "R5 one strobe per frame", upd_pulses, 1);
  endtask

  task automatic dev_reset(logic lvl);
    exp_lvl = lvl; rst_sel = lvl; rst_req = 1'b1;
    @(negedge sys_clk);
    rst_req = 1'b0;
    chk(busy && dev_rst_lvl == lvl, "R7 level applied at once", dev_rst_lvl, lvl);
    wait_idle();
    chk(dev_rst_n, "R7 reset released", dev_rst_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge sys_clk);
    sys_rst_n = 1'b1;
    @(negedge sys_clk);
    chk(ser_sel_n && !ser_clk && !ser_dat && upd_n, "R3 idle bus levels",
        {ser_sel_n, ser_clk, ser_dat, upd_n}, 9);
    chk(dev_rst_n && !busy && wr_ready, "R6 idle handshake", {dev_rst_n, busy, wr_ready}, 5);
    mon_on = 1'b1;
    @(negedge sys_clk);

    // sweep every channel over a set of code patterns
    for (int a = 0; a < 4; a++) begin
      send(2'(a), 12'h000);
      send(2'(a), 12'hfff);
      send(2'(a), 12'h555);
      send(2'(a), 12'haaa);
      for (int b = 0; b < 12; b++) send(2'(a), 12'(1 << b));
    end

    // R7 reset sequences with both levels
    dev_reset(1'b1);
    dev_reset(1'b0);

    // R8 reset and write requested in the same idle cycle
    exp_lvl = 1'b1; rst_sel = 1'b1; rst_req = 1'b1;
    exp_frame = 16'(2 * 16384 + 12'h3c5);
    wr_addr = 2'd2; wr_code = 12'h3c5; wr_valid = 1'b1;
    #1;
    chk(!wr_ready, "R8 ready held low by reset request", wr_ready, 0);
    @(negedge sys_clk);
    rst_req = 1'b0;
    chk(busy && ser_sel_n, "R8 reset taken first", {busy, ser_sel_n}, 3);
    while (!dev_rst_n || busy) begin
      chk(ser_sel_n, "R8 write held during reset", ser_sel_n, 1);
      @(negedge sys_clk);
      if (!busy) break;
    end
    while (ser_sel_n) @(negedge sys_clk);
    wr_valid = 1'b0;
    wait_idle();
    chk(upd_pulses == 1, "R8 pending write sent after reset", upd_pulses, 1);

    // back-to-back writes with valid held high
    send(2'd3, 12'h81f);
    send(2'd1, 12'h7e0);

    repeat (5) @(negedge sys_clk);
    finish_run();
  end
endmodule